// File: doc/BRIEF.md
# Table-Driven Complex Phase Derotator

This block removes a residual carrier rotation from a stream of complex baseband samples. It does this by multiplying each sample by the conjugate of a unit phasor. A phase estimate from an external tracking loop selects an entry in an internal table. Each table entry holds the sine and cosine of one phase step, packed into a single word. One table read therefore supplies both factors of the complex product, and the product is rounded back to the sample width. A two-bit code gives the signal-plane quadrant of every corrected sample, so a downstream symbol decision can use it as its phase reference.

Phase estimates arrive at any time on a load strobe and are held as pending. A pending estimate takes effect only when the sample stream marks the first sample of a new observation window. The estimate produced during one window therefore corrects every sample of the following window, and no sample partway through a window sees a change. The pipeline accepts one sample per clock, and its fixed latency is two cycles.

Top module: `phase_derotator`

## Requirements
- R1: While reset is asserted (rstN low) and after its release, outValid is 0, outI, outQ and outQuad are 0, and the pending and active phases are 0.
- R2: One sample may be accepted on every clock, and outValid is high exactly two clock cycles after a cycle with inValid high. Results leave in the order the samples arrived.
- R3: The phase index k (10 bits, unit π/512, 1024 entries per turn) selects a 32-bit table word. Its bits [31:16] hold round(32767·sin(2πk/1024)) and its bits [15:0] hold round(32767·cos(2πk/1024)), both two's complement.
- R4: With c and s the table cosine and sine, outI = (I·c + Q·s + 16384) >>> 15 and outQ = (Q·c − I·s + 16384) >>> 15, where >>> is an arithmetic shift on the exact product sum.
- R5: A rounded result above 32767 is output as 32767, and one below −32767 is output as −32767. The value −32768 never appears on outI or outQ.
- R6: outQuad encodes the signs of the corrected sample: 0 for outI ≥ 0 and outQ ≥ 0, 1 for outI < 0 and outQ ≥ 0, 2 for outI < 0 and outQ < 0, 3 for outI ≥ 0 and outQ < 0.
- R7: A cycle with phaseLoad high stores phaseIn as the pending phase, and the samples of the current window are not affected. The pending phase becomes active on a cycle with inValid and winFirst both high, and that sample and all later ones use it.
- R8: When phaseLoad coincides with a window start, that window uses the pending value held before the cycle. The newly loaded value waits for the next window start.
- R9: In cycles with outValid low, outI, outQ and outQuad keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input sample present |
| winFirst | input | 1 | Marks the first sample of a window, qualified by inValid |
| inI | input | 16 | In-phase input sample, signed |
| inQ | input | 16 | Quadrature input sample, signed |
| phaseLoad | input | 1 | Stores phaseIn as the pending phase |
| phaseIn | input | 10 | New phase estimate, unit π/512 |
| outValid | output | 1 | Corrected sample present |
| outI | output | 16 | Corrected in-phase sample, signed |
| outQ | output | 16 | Corrected quadrature sample, signed |
| outQuad | output | 2 | Quadrant code of the corrected sample |

## Verification
The assertions assume that reset is held for at least two clocks, so that the two-cycle valid history is defined. They also assume that inValid, winFirst and phaseLoad are never unknown outside reset. The stimulus drives every control input to a known level on each falling edge, including in idle cycles, and holds reset low for several cycles at the start. The driver models the pending and active phase exactly as R7 and R8 state, so every expected result follows from the window markers it sends. This includes the collision of a phase load with a window start.

// File: rtl/derot_pkg.sv
package derot_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capStage1;  // accept a new input sample and its table word
    logic capOut;     // register the derotated result
  } derot_strb_t;

  typedef enum logic [1:0] {
    QUAD_PP = 2'd0,
    QUAD_NP = 2'd1,
    QUAD_NN = 2'd2,
    QUAD_PN = 2'd3
  } derot_quad_e;

endpackage

// File: rtl/derot_ctrl.sv
module derot_ctrl
  import derot_pkg::*;
#(
  parameter int PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               winFirst,
  input  logic               phaseLoad,
  input  logic [PHASE_W-1:0] phaseIn,
  output derot_strb_t        strb,
  output logic [PHASE_W-1:0] tableIdx,
  output logic               outValid
);

  logic [PHASE_W-1:0] pendPhase;
  logic [PHASE_W-1:0] actPhase;
  logic               stage1Valid;
  logic               winSwap;

  assign winSwap = inValid && winFirst;

  // pending estimate, loaded at any time
  always_ff @(posedge clk) begin
    if (!rstN)          pendPhase <= '0;
    else if (phaseLoad) pendPhase <= phaseIn;
  end

  // active estimate, moves only at a window start
  always_ff @(posedge clk) begin
    if (!rstN)        actPhase <= '0;
    else if (winSwap) actPhase <= pendPhase;
  end

  // first sample of a window already uses the value it brings in
  assign tableIdx = winSwap ? pendPhase : actPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  always_comb begin
    strb.capStage1 = inValid;
    strb.capOut    = stage1Valid;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid, 2)); // R2

  AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !winSwap |=> $stable(actPhase)); // R7

  AST_LOAD_DEFERRED: assert property (@(posedge clk) disable iff (!rstN)
    (phaseLoad && winSwap) |=> actPhase == $past(pendPhase)); // R8

endmodule

// File: rtl/derot_datapath.sv
module derot_datapath
  import derot_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int PHASE_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  derot_strb_t              strb,
  input  logic [PHASE_W-1:0]       tableIdx,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ,
  output logic [1:0]               outQuad
);

  localparam int TABLE_DEPTH = 1 << PHASE_W;
  localparam int WORD_W      = 2 * COEF_W;
  localparam int ACC_W       = DATA_W + COEF_W + 1;
  localparam int SHIFT       = COEF_W - 1;
  localparam int COEF_SCALE  = (1 << (COEF_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1 << (SHIFT - 1));
  localparam logic signed [ACC_W-1:0] SAT_MAX  = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_MIN  = -SAT_MAX;

  // packed table: sine in the upper half, cosine in the lower half
  logic [WORD_W-1:0] sincosRom [TABLE_DEPTH];

  initial begin
    for (int k = 0; k < TABLE_DEPTH; k++) begin
      real ang;
      int  sv;
      int  cv;
      ang = 2.0 * 3.14159265358979 * real'(k) / real'(TABLE_DEPTH);
      sv  = int'(real'(COEF_SCALE) * $sin(ang));
      cv  = int'(real'(COEF_SCALE) * $cos(ang));
      sincosRom[k] = {COEF_W'(sv), COEF_W'(cv)};
    end
  end

  // stage 1: sample and table word
  logic signed [DATA_W-1:0] s1I;
  logic signed [DATA_W-1:0] s1Q;
  logic [WORD_W-1:0]        romWord;

  always_ff @(posedge clk) begin
    if (strb.capStage1) romWord <= sincosRom[tableIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1I <= '0;
      s1Q <= '0;
    end else if (strb.capStage1) begin
      s1I <= inI;
      s1Q <= inQ;
    end
  end

  // stage 2: complex multiply by the conjugate phasor
  logic signed [COEF_W-1:0] cosV;
  logic signed [COEF_W-1:0] sinV;
  logic signed [ACC_W-1:0]  accI;
  logic signed [ACC_W-1:0]  accQ;
  logic signed [DATA_W-1:0] resI;
  logic signed [DATA_W-1:0] resQ;
  logic [1:0]               resQuad;

  function automatic logic signed [DATA_W-1:0] roundSat(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] sh;
    sh = (acc + HALF_LSB) >>> SHIFT;
    if (sh > SAT_MAX)      return DATA_W'(SAT_MAX);
    else if (sh < SAT_MIN) return DATA_W'(SAT_MIN);
    else                   return DATA_W'(sh);
  endfunction

  always_comb begin
    sinV = romWord[WORD_W-1:COEF_W];
    cosV = romWord[COEF_W-1:0];
    accI = ACC_W'(s1I) * ACC_W'(cosV) + ACC_W'(s1Q) * ACC_W'(sinV);
    accQ = ACC_W'(s1Q) * ACC_W'(cosV) - ACC_W'(s1I) * ACC_W'(sinV);
    resI = roundSat(accI);
    resQ = roundSat(accQ);
    unique case ({resI[DATA_W-1], resQ[DATA_W-1]})
      2'b00:   resQuad = QUAD_PP;
      2'b10:   resQuad = QUAD_NP;
      2'b11:   resQuad = QUAD_NN;
      default: resQuad = QUAD_PN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outI    <= '0;
      outQ    <= '0;
      outQuad <= '0;
    end else if (strb.capOut) begin
      outI    <= resI;
      outQ    <= resQ;
      outQuad <= resQuad;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capOut |=> ($stable(outI) && $stable(outQ) && $stable(outQuad))); // R9

  AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rstN)
    (outI != DATA_W'(SAT_MIN - 1)) && (outQ != DATA_W'(SAT_MIN - 1))); // R5

  AST_ORIGIN_QUAD: assert property (@(posedge clk) disable iff (!rstN)
    (outI == '0 && outQ == '0) |-> outQuad == QUAD_PP); // R6

endmodule

// File: rtl/phase_derotator.sv
module phase_derotator
  import derot_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int PHASE_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     winFirst,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     phaseLoad,
  input  logic [PHASE_W-1:0]       phaseIn,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ,
  output logic [1:0]               outQuad
);

  derot_strb_t        strb;
  logic [PHASE_W-1:0] tableIdx;

  derot_ctrl #(.PHASE_W(PHASE_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .winFirst (winFirst),
    .phaseLoad(phaseLoad),
    .phaseIn  (phaseIn),
    .strb     (strb),
    .tableIdx (tableIdx),
    .outValid (outValid)
  );

  derot_datapath #(.DATA_W(DATA_W), .COEF_W(COEF_W), .PHASE_W(PHASE_W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .tableIdx(tableIdx),
    .inI     (inI),
    .inQ     (inQ),
    .outI    (outI),
    .outQ    (outQ),
    .outQuad (outQuad)
  );

endmodule

// File: tb/test_phase_derotator.sv
module test_phase_derotator;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1024;

  logic               clk = 1'b0;
  logic               rstN;
  logic               inValid;
  logic               winFirst;
  logic signed [15:0] inI;
  logic signed [15:0] inQ;
  logic               phaseLoad;
  logic [9:0]         phaseIn;
  logic               outValid;
  logic signed [15:0] outI;
  logic signed [15:0] outQ;
  logic [1:0]         outQuad;

  phase_derotator i_phase_derotator (
    .clk(clk), .rstN(rstN), .inValid(inValid), .winFirst(winFirst),
    .inI(inI), .inQ(inQ), .phaseLoad(phaseLoad), .phaseIn(phaseIn),
    .outValid(outValid), .outI(outI), .outQ(outQ), .outQuad(outQuad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int     ei;
    int     eq;
    int     equad;
    longint due;
    string  tag;
  } exp_t;

  exp_t   sbQueue[$];
  int     nChecks = 0;
  int     nFails  = 0;
  longint cyc     = 0;
  int     modelPend = 0;
  int     modelAct  = 0;
  logic signed [15:0] lastI = '0;
  logic signed [15:0] lastQ = '0;
  logic [1:0]         lastQuad = '0;
  bit     monitorOn = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sinq(int k);
    return int'(32767.0 * $sin(2.0 * 3.14159265358979 * real'(k) / real'(DEPTH)));
  endfunction

  function automatic int cosq(int k);
    return int'(32767.0 * $cos(2.0 * 3.14159265358979 * real'(k) / real'(DEPTH)));
  endfunction

  function automatic int satr(longint acc);
    longint sh;
    sh = (acc + 64'sd16384) >>> 15;
    if (sh > 32767)  return 32767;
    if (sh < -32767) return -32767;
    return int'(sh);
  endfunction

  function automatic int quadOf(int re, int im);
    if (re >= 0 && im >= 0) return 0;
    if (re < 0 && im >= 0)  return 1;
    if (re < 0)             return 2;
    return 3;
  endfunction

  task automatic check(string tag, int act, int expv);
    nChecks++;
    if (act != expv) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: one input sample, optional phase load in the same cycle
  task automatic send(int i, int q, bit first, bit load, int loadVal, string tag);
    exp_t e;
    int   k;
    longint ai;
    longint aq;
    @(negedge clk);
    inValid   = 1'b1;
    winFirst  = first;
    inI       = 16'(i);
    inQ       = 16'(q);
    phaseLoad = load;
    phaseIn   = 10'(loadVal);
    k  = first ? modelPend : modelAct;
    ai = longint'(i) * cosq(k) + longint'(q) * sinq(k);
    aq = longint'(q) * cosq(k) - longint'(i) * sinq(k);
    e.ei    = satr(ai);
    e.eq    = satr(aq);
    e.equad = quadOf(e.ei, e.eq);
    e.due   = cyc + 2;
    e.tag   = tag;
    sbQueue.push_back(e);
    if (first) modelAct = modelPend;
    if (load)  modelPend = loadVal;
  endtask

  task automatic idle(int n, bit load, int loadVal);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      inValid   = 1'b0;
      winFirst  = 1'b0;
      phaseLoad = (c == 0) ? load : 1'b0;
      phaseIn   = 10'(loadVal);
      inI       = 16'sh5a5a;
      inQ       = -16'sh1234;
      if (c == 0 && load) modelPend = loadVal;
    end
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (monitorOn) begin
      if (outValid) begin
        if (sbQueue.size() == 0) begin
          check("R2 unexpected outValid", 1, 0);
        end else begin
          exp_t e;
          e = sbQueue.pop_front();
          check({e.tag, " R2 latency"}, int'(cyc), int'(e.due));
          check({e.tag, " outI"}, int'(outI), e.ei);
          check({e.tag, " outQ"}, int'(outQ), e.eq);
          check("R6 quadrant", int'(outQuad), e.equad);
        end
      end else begin
        check("R9 outI hold", int'(outI), int'(lastI));
        check("R9 outQ hold", int'(outQ), int'(lastQ));
        check("R9 quad hold", int'(outQuad), int'(lastQuad));
      end
      lastI    = outI;
      lastQ    = outQ;
      lastQuad = outQuad;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; winFirst = 1'b0; inI = '0; inQ = '0;
    phaseLoad = 1'b0; phaseIn = '0;
    repeat (5) @(negedge clk);
    // R1: outputs during reset
    check("R1 outValid", int'(outValid), 0);
    check("R1 outI", int'(outI), 0);
    check("R1 outQuad", int'(outQuad), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outQ after release", int'(outQ), 0);
    monitorOn = 1'b1;

    // R4: phase 0 after reset, several patterns back to back
    send(1000, -2000, 1'b0, 1'b0, 0, "R4 phase0");
    send(-32768, 32767, 1'b0, 1'b0, 0, "R4 phase0 extremes");
    send(0, 0, 1'b0, 1'b0, 0, "R6 origin");
    send(-5, -7, 1'b0, 1'b0, 0, "R4 small");
    idle(3, 1'b0, 0);

    // R7: load quarter turn mid-window, no effect until a window start
    send(12000, 3000, 1'b0, 1'b1, 256, "R7 load cycle");
    send(12000, 3000, 1'b0, 1'b0, 0, "R7 same window");
    idle(2, 1'b0, 0);
    send(12000, 3000, 1'b1, 1'b0, 0, "R7 window start");
    send(-9000, 4000, 1'b0, 1'b0, 0, "R7 next window body");

    // R3: table probe at several indices using a full-scale real input
    for (int n = 0; n < 9; n++) begin
      int idxs[9] = '{1, 100, 255, 300, 511, 512, 700, 896, 1023};
      idle(1, 1'b1, idxs[n]);
      send(32767, 0, 1'b1, 1'b0, 0, "R3 table");
      send(0, 32767, 1'b0, 1'b0, 0, "R3 table sine");
    end

    // R8: load coinciding with a window start
    idle(1, 1'b1, 128);
    send(20000, -15000, 1'b1, 1'b1, 640, "R8 collide uses old");
    send(20000, -15000, 1'b0, 1'b0, 0, "R8 window body");
    send(20000, -15000, 1'b1, 1'b0, 0, "R8 next window new");

    // R5: saturation at minus an eighth turn and at half turn with most negative input
    idle(1, 1'b1, 896);
    send(32767, 32767, 1'b1, 1'b0, 0, "R5 sat positive");
    send(-32768, -32768, 1'b0, 1'b0, 0, "R5 sat negative");
    idle(1, 1'b1, 512);
    send(-32768, 0, 1'b1, 1'b0, 0, "R5 half turn");

    // R6 and R2: quadrant sweep, continuous stream
    idle(1, 1'b1, 0);
    send(100, 100, 1'b1, 1'b0, 0, "R6 q0");
    send(-100, 100, 1'b0, 1'b0, 0, "R6 q1");
    send(-100, -100, 1'b0, 1'b0, 0, "R6 q2");
    send(100, -100, 1'b0, 1'b0, 0, "R6 q3");
    send(0, -1, 1'b0, 1'b0, 0, "R6 axis");
    idle(6, 1'b0, 0);

    check("R2 scoreboard drained", sbQueue.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule